// File: doc/BRIEF.md
# Tick-Gated Integrate-and-Fire Neuron

This block models one spiking neuron. Each incoming spike event carries an unsigned synaptic increment, and the block adds it to an internal integrand register. The neuron fires only when a strobe from a coarse wallclock timer arrives. At each tick the integrand is compared with a programmable threshold. If the integrand has reached the threshold, the integrand goes back to zero and a one-cycle spike strobe is emitted. Otherwise the tick has no effect.

The neuron has no leak. Events that arrive between two ticks therefore add up in the integrand until the next tick. Event delivery is taken as instantaneous, and the tick is the only time base the model uses. The threshold is captured while the neuron is held in reset and stays fixed while the neuron runs.

Top module: `tick_gated_neuron`

## Requirements
- R1: A cycle with `evt_valid` high adds `evt_weight` to the integrand. With no tick, `spike_out` stays low no matter how much has built up.
- R2: `spike_out` can be high only in the cycle right after a cycle with `tick` high. A tick produces at most one spike, and each spike lasts one cycle.
- R3: At a tick, an integrand greater than or equal to the threshold makes the neuron fire. An integrand exactly equal to the threshold also fires. After a firing tick the integrand is zero.
- R4: At a tick, an integrand below the threshold gives no spike, and the integrand keeps its value for later ticks.
- R5: When an event and a tick fall in the same cycle, the event's weight is added first. The threshold test uses that updated sum.
- R6: The integrand is 16 bits wide. It saturates at 65535 and does not wrap. A saturated integrand fires against a threshold of 65535.
- R7: The threshold takes `thr_value` on a clock edge with `rst_n` low and `thr_load` high. On a reset edge with `thr_load` low it takes the parameter default. A `thr_load` pulse while `rst_n` is high has no effect.
- R8: On a clock edge with `rst_n` low, `spike_out` goes low and the integrand is cleared to zero.
- R9: A threshold of zero makes every tick fire, even when the integrand is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the threshold load window |
| evt_valid | input | 1 | Incoming spike event strobe |
| evt_weight | input | 8 | Synaptic increment carried by the event |
| tick | input | 1 | Wallclock timer tick strobe |
| thr_load | input | 1 | Threshold load enable, honoured only during reset |
| thr_value | input | 16 | Threshold value to load |
| spike_out | output | 1 | One-cycle output spike strobe |

## Verification
The integrand has no port of its own, so a wrong integrand value only shows as a spike that is present or missing at the next tick. A wrap instead of saturation, a lost event weight, or a missing clear after firing all shift the firing pattern. The bench therefore sets up sums that land just below, exactly at and just above the threshold, then ticks and observes the next cycle. A threshold that changed while running is caught the same way, one cycle after the first tick that separates the two values.

// File: rtl/neuron_pkg.sv
// Package: shared widths and types of the tick-gated neuron.
// Assumes: unsigned increments and an unsigned integrand.
package neuron_pkg;
    localparam int INTEG_W = 16;
    localparam int WEIGHT_W = 8;
    typedef logic [INTEG_W-1:0] integ_t;
    typedef logic [WEIGHT_W-1:0] weight_t;
endpackage

// File: rtl/nrn_thresh_reg.sv
// Threshold register. Loads only on a reset edge: thr_value when load is
// high, otherwise DEFAULT_THR. Holds its value while the neuron runs.
module nrn_thresh_reg #(
    parameter int W = 16,
    parameter logic [W-1:0] DEFAULT_THR = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic [W-1:0] thr_o
);
    logic [W-1:0] thr_q;

    // Capture the threshold in the reset window only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= load_i ? value_i : DEFAULT_THR;
        end
    end

    assign thr_o = thr_q;

    AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(thr_q)); // R7
endmodule

// File: rtl/nrn_accum.sv
// Integrand accumulator. Adds an event weight each cycle it is valid,
// saturating at the all-ones value. Clears on reset and when told that the
// neuron fired. Assumes clr_i is derived from the sum exported here.
module nrn_accum #(
    parameter int IW = 16,
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_i,
    input  logic [WW-1:0] weight_i,
    input  logic          clr_i,
    output logic [IW-1:0] sum_o,
    output logic [IW-1:0] integ_o
);
    localparam int SW = IW + 1;
    localparam logic [IW-1:0] SAT = '1;

    logic [IW-1:0] integ_q;
    logic [SW-1:0] wide;

    // Saturating sum of the stored integrand and this cycle's increment
    always_comb begin
        wide = {1'b0, integ_q} + (add_i ? SW'(weight_i) : '0);
        sum_o = wide[IW] ? SAT : wide[IW-1:0];
    end

    // Store the new integrand, or zero after a firing tick
    always_ff @(posedge clk) begin
        if (!rst_n)     integ_q <= '0;
        else if (clr_i) integ_q <= '0;
        else            integ_q <= sum_o;
    end

    assign integ_o = integ_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_i)) |-> (integ_q >= $past(integ_q))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_i) && !$past(add_i)) |-> $stable(integ_q)); // R4
endmodule

// File: rtl/nrn_fire_ctrl.sv
// Fire decision. At a tick, compares the updated sum with the threshold,
// requests a clear and registers a one-cycle spike. Assumes tick_i is a
// strobe.
module nrn_fire_ctrl #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [IW-1:0] sum_i,
    input  logic [IW-1:0] thr_i,
    output logic          fire_o,
    output logic          spike_o
);
    logic spike_q;

    // Fire only at a tick whose sum has reached the threshold
    always_comb fire_o = tick_i && (sum_i >= thr_i);

    // Register the output strobe
    always_ff @(posedge clk) begin
        if (!rst_n) spike_q <= 1'b0;
        else        spike_q <= fire_o;
    end

    assign spike_o = spike_q;

    AST_SPIKE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |-> $past(tick_i)); // R2
    AST_BELOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick_i) && ($past(sum_i) < $past(thr_i))) |-> !spike_q); // R4
endmodule

// File: rtl/tick_gated_neuron.sv
// Top: integrate-and-fire neuron that decides to fire only on timer ticks.
// Assumes synchronous active-low reset and a threshold loaded during reset.
module tick_gated_neuron
    import neuron_pkg::*;
#(
    parameter integ_t DEFAULT_THR = integ_t'(16'd100)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [WEIGHT_W-1:0] evt_weight,
    input  logic                tick,
    input  logic                thr_load,
    input  logic [INTEG_W-1:0]  thr_value,
    output logic                spike_out
);
    integ_t thr, sum, integ;
    logic   fire;

    nrn_thresh_reg #(.W(INTEG_W), .DEFAULT_THR(DEFAULT_THR)) u_thr (
        .clk(clk), .rst_n(rst_n), .load_i(thr_load),
        .value_i(thr_value), .thr_o(thr)
    );

    nrn_accum #(.IW(INTEG_W), .WW(WEIGHT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .add_i(evt_valid), .weight_i(evt_weight),
        .clr_i(fire), .sum_o(sum), .integ_o(integ)
    );

    nrn_fire_ctrl #(.IW(INTEG_W)) u_fire (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sum_i(sum),
        .thr_i(thr), .fire_o(fire), .spike_o(spike_out)
    );

    AST_CLEAR_ON_SPIKE: assert property (@(posedge clk) disable iff (!rst_n)
        spike_out |-> (integ == '0)); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (!spike_out && integ == '0)); // R8
endmodule

// File: tb/test_tick_gated_neuron.sv
module test_tick_gated_neuron;
    localparam time CLK_PERIOD = 10ns;
    localparam int NV = 12;
    // {evt_valid, weight, tick, expected spike}
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 8'd4, 1'b0, 1'b0},   // R1 accumulate 4
        {1'b0, 8'd0, 1'b1, 1'b0},   // R4 4 < 10
        {1'b1, 8'd6, 1'b0, 1'b0},   // R1 reach 10, no tick
        {1'b0, 8'd0, 1'b1, 1'b1},   // R3 equal fires
        {1'b0, 8'd0, 1'b1, 1'b0},   // R3 cleared to 0
        {1'b1, 8'd9, 1'b1, 1'b0},   // R5 9 < 10
        {1'b1, 8'd1, 1'b1, 1'b1},   // R5 9+1 fires same cycle
        {1'b1, 8'd3, 1'b0, 1'b0},
        {1'b1, 8'd3, 1'b0, 1'b0},
        {1'b1, 8'd5, 1'b1, 1'b1},   // R3 11 > 10
        {1'b0, 8'd0, 1'b0, 1'b0},   // R2 single cycle
        {1'b0, 8'd0, 1'b1, 1'b0}    // R3 cleared
    };

    logic clk = 0, rst_n = 0, evt_valid = 0, tick = 0, thr_load = 0;
    logic [7:0] evt_weight = '0;
    logic [15:0] thr_value = '0;
    logic spike_out;
    int checks = 0, fails = 0;
    bit done = 0;

    tick_gated_neuron i_tick_gated_neuron (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_weight(evt_weight),
        .tick(tick), .thr_load(thr_load), .thr_value(thr_value), .spike_out(spike_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic exp, input string req);
        checks++;
        if (spike_out !== exp) begin
            fails++;
            $display("FAIL %s spike_out=%b expected=%b", req, spike_out, exp);
        end
    endtask

    // drive one cycle from a negedge, return at the next negedge
    task automatic cyc(input logic e, input logic [7:0] w, input logic t);
        evt_valid = e; evt_weight = w; tick = t;
        @(negedge clk);
        evt_valid = 0; evt_weight = '0; tick = 0;
    endtask

    task automatic do_reset(input logic ld, input logic [15:0] v);
        rst_n = 0; thr_load = ld; thr_value = v;
        @(negedge clk); @(negedge clk);
        check(1'b0, "R8");
        rst_n = 1; thr_load = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired spike_out=%b expected=finish", spike_out);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1, 16'd10);
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][10], VEC[i][9:2], VEC[i][1]);
            check(VEC[i][0], $sformatf("R3/R4/R5 vector %0d", i));
        end
        // R8: reset mid-run clears the integrand
        cyc(1'b1, 8'd9, 1'b0);
        do_reset(1'b1, 16'd10);
        cyc(1'b1, 8'd1, 1'b1);
        check(1'b0, "R8 integrand cleared by reset");
        // R7: load ignored outside reset (threshold stays 10)
        thr_load = 1; thr_value = 16'd100;
        cyc(1'b1, 8'd19, 1'b0);
        thr_load = 0;
        cyc(1'b0, 8'd0, 1'b1);
        check(1'b1, "R7 run-time load ignored");
        // R7: load of 100 in reset
        do_reset(1'b1, 16'd100);
        cyc(1'b1, 8'd99, 1'b1);
        check(1'b0, "R7 99 below loaded 100");
        cyc(1'b1, 8'd1, 1'b1);
        check(1'b1, "R7 100 reaches loaded 100");
        // R7: reset without load gives default 100
        do_reset(1'b0, 16'd5);
        cyc(1'b1, 8'd50, 1'b1);
        check(1'b0, "R7 default threshold 100");
        // R9: zero threshold fires every tick
        do_reset(1'b1, 16'd0);
        cyc(1'b0, 8'd0, 1'b1);
        check(1'b1, "R9 zero threshold");
        cyc(1'b0, 8'd0, 1'b1);
        check(1'b1, "R9 zero threshold again");
        // R6: saturation, 300*255 > 65535
        do_reset(1'b1, 16'hFFFF);
        for (int k = 0; k < 300; k++) cyc(1'b1, 8'd255, 1'b0);
        check(1'b0, "R1 no spike without tick");
        cyc(1'b0, 8'd0, 1'b1);
        check(1'b1, "R6 saturated integrand fires");
        cyc(1'b0, 8'd0, 1'b1);
        check(1'b0, "R6 cleared after saturated fire");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule